// File: doc/BRIEF.md
# 8-bit ALU with Flag Register and Branch Condition Evaluator

This block is the arithmetic and logic unit of a small 8-bit processor core. For the operation on `op_sel` it computes an 8-bit result from a destination operand `opnd_a` and a source operand `opnd_b`. It also computes a new set of six status flags: carry C, zero Z, sign S, overflow V, decimal-subtract D and half-carry H. The datapath is purely combinational. `result` follows the inputs in the same cycle.

The flags live in a register inside the block. The ALU reads that register for its carry-in, and for the D, H and C inputs of decimal adjust. A flag write enable commits the freshly computed flags on the next rising clock edge. A separate flag load port lets the surrounding core restore a saved flag byte, for example on a return from an interrupt.

A 4-bit condition code is evaluated against the registered flags. It produces a take-branch output for conditional jumps. Word arithmetic and instruction sequencing belong to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, `flags_out` is 0. The flag bits are C=[5], Z=[4], S=[3], V=[2], D=[1], H=[0].
- R2: On a rising edge, `flag_ld`=1 loads `flag_in` into the flags (this has priority). Otherwise `flag_we`=1 loads the ALU's new flags. Otherwise the flags hold.
- R3: ADD (op 0) and ADC (op 1, which adds C) write a+b(+C). C is the carry out of bit 7. H is the carry out of bit 3. V is signed overflow. D=0. Z and S follow the result.
- R4: SUB (op 2) and SBC (op 3, which also subtracts C) write a-b(-C). C=1 on borrow from bit 7. H=1 on borrow from bit 3. V is signed overflow. D=1. CP (op 4) sets C, Z, S and V the same way, leaves D and H unchanged, and `result` equals `opnd_a`.
- R5: AND (5), OR (6), XOR (7) and COM (8, which gives NOT a) set Z and S from the result and clear V. C, D and H are unchanged.
- R6: INC (9) and DEC (10) write a+1 and a-1. Z and S follow the result and V is signed overflow. C, D and H are unchanged.
- R7: RL (11) writes {a[6:0],a[7]} with C=a[7]. RLC (12) writes {a[6:0],C} with C=a[7]. RR (13) writes {a[0],a[7:1]} with C=a[0]. RRC (14) writes {C,a[7:1]} with C=a[0]. For all four, V=a[7] XOR result[7], Z and S follow the result, and D and H are unchanged.
- R8: SRA (15) writes {a[7],a[7:1]} with C=a[0] and V=0. SWAP (16) exchanges the nibbles and changes only Z and S.
- R9: DA (17) corrects a to two BCD digits. With D=0, it adds 0x06 if H=1 or the low digit is above 9. It adds 0x60 if C=1 or a>0x99, and that case also sets C. With D=1, it subtracts 0x06 if H=1 and 0x60 if C=1, and C is kept. Z and S follow the result, and V, D and H are unchanged.
- R10: TM (18) sets Z from (a AND b)==0. TCM (19) sets Z from ((NOT a) AND b)==0. In both, S is bit 7 of the masked value, V=0, and C, D and H are unchanged. `result` equals `opnd_a`. Op codes 20 to 31 give result=a and change no flag.
- R11: `branch_take` evaluates `cc_sel` against the registered flags as follows:
  - 0000 is false and 1000 is true.
  - 0001 is S^V and 1001 is !(S^V).
  - 0010 is Z|(S^V) and 1010 is its negation.
  - 0011 is C|Z and 1011 is its negation.
  - 0100 is V and 1100 is !V.
  - 0101 is S and 1101 is !S.
  - 0110 is Z and 1110 is !Z.
  - 0111 is C and 1111 is !C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 5 | Operation select |
| opnd_a | input | 8 | Destination operand |
| opnd_b | input | 8 | Source operand or mask |
| flag_we | input | 1 | Commit ALU flags at the next edge |
| flag_ld | input | 1 | Load `flag_in` into the flags at the next edge |
| flag_in | input | 6 | Flag value for a load |
| cc_sel | input | 4 | Condition code to evaluate |
| result | output | 8 | ALU result (combinational) |
| flags_out | output | 6 | Registered flags |
| branch_take | output | 1 | Condition code is true |

## Verification
The bench builds the block with its package defaults: an 8-bit datapath, 5-bit operation select and 4-bit condition code. These defaults bring the nibble boundary, the 0x99 decimal threshold and the sign bit within reach of directed operands. The condition evaluator is swept over all 16 codes against all 64 flag values. Decimal adjust is checked after real additions and subtractions, whose flags were committed through the write enable.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 5;
  localparam int CC_W   = 4;
  localparam int FLAG_W = 6;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CP   = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
    OP_COM  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_RL   = 5'd11,
    OP_RLC  = 5'd12, OP_RR   = 5'd13, OP_RRC  = 5'd14, OP_SRA  = 5'd15,
    OP_SWAP = 5'd16, OP_DA   = 5'd17, OP_TM   = 5'd18, OP_TCM  = 5'd19
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
    logic d;
    logic h;
  } flags_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  alu_op_e            op,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  input  flags_t             fin,
  output logic [DATA_W-1:0]  res,
  output flags_t             fout
);
  localparam int MSB = DATA_W - 1;
  localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
  localparam logic [DATA_W-1:0] BYTE_MAX = DATA_W'(8'h99);
  localparam logic [NIB_W-1:0] FIX = NIB_W'(6);

  logic              cin;
  logic [DATA_W:0]   wide;
  logic [NIB_W:0]    nib;
  logic              lo_fix, hi_fix;
  logic [DATA_W-1:0] corr;

  always_comb begin
    res    = a;
    fout   = fin;
    cin    = 1'b0;
    wide   = '0;
    nib    = '0;
    lo_fix = 1'b0;
    hi_fix = 1'b0;
    corr   = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        cin    = (op == OP_ADC) ? fin.c : 1'b0;
        wide   = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        nib    = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
        res    = wide[DATA_W-1:0];
        fout.c = wide[DATA_W];
        fout.h = nib[NIB_W];
        fout.v = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
        fout.d = 1'b0;
      end
      OP_SUB, OP_SBC, OP_CP: begin
        cin    = (op == OP_SBC) ? fin.c : 1'b0;
        wide   = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
        nib    = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin};
        res    = wide[DATA_W-1:0];
        fout.c = wide[DATA_W];
        fout.v = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
        if (op != OP_CP) begin
          fout.h = nib[NIB_W];
          fout.d = 1'b1;
        end
      end
      OP_INC: begin
        res    = a + DATA_W'(1);
        fout.v = !a[MSB] && res[MSB];
      end
      OP_DEC: begin
        res    = a - DATA_W'(1);
        fout.v = a[MSB] && !res[MSB];
      end
      OP_DA: begin
        lo_fix = fin.d ? fin.h : (fin.h || (a[NIB_W-1:0] > DIGIT_MAX));
        hi_fix = fin.d ? fin.c : (fin.c || (a > BYTE_MAX));
        corr   = {(hi_fix ? FIX : '0), (lo_fix ? FIX : '0)};
        res    = fin.d ? (a - corr) : (a + corr);
        fout.c = fin.d ? fin.c : hi_fix;
      end
      default: ;
    endcase
    fout.z = (res == '0);
    fout.s = res[MSB];
    if (op == OP_CP) res = a;
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  alu_op_e            op,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  input  flags_t             fin,
  output logic [DATA_W-1:0]  res,
  output flags_t             fout
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] zval;
  logic              touch;

  always_comb begin
    res   = a;
    fout  = fin;
    zval  = a;
    touch = 1'b1;
    case (op)
      OP_AND: begin res = a & b; fout.v = 1'b0; end
      OP_OR:  begin res = a | b; fout.v = 1'b0; end
      OP_XOR: begin res = a ^ b; fout.v = 1'b0; end
      OP_COM: begin res = ~a;    fout.v = 1'b0; end
      OP_RL:  begin res = {a[MSB-1:0], a[MSB]}; fout.c = a[MSB]; end
      OP_RLC: begin res = {a[MSB-1:0], fin.c};  fout.c = a[MSB]; end
      OP_RR:  begin res = {a[0], a[MSB:1]};     fout.c = a[0];   end
      OP_RRC: begin res = {fin.c, a[MSB:1]};    fout.c = a[0];   end
      OP_SRA: begin res = {a[MSB], a[MSB:1]};   fout.c = a[0]; fout.v = 1'b0; end
      OP_SWAP: res = {a[NIB_W-1:0], a[DATA_W-1:NIB_W]};
      OP_TM:   begin zval = a & b;  fout.v = 1'b0; end
      OP_TCM:  begin zval = ~a & b; fout.v = 1'b0; end
      default: touch = 1'b0;
    endcase
    if (op == OP_RL || op == OP_RLC || op == OP_RR || op == OP_RRC)
      fout.v = a[MSB] ^ res[MSB];
    if (op != OP_TM && op != OP_TCM) zval = res;
    if (touch) begin
      fout.z = (zval == '0);
      fout.s = zval[MSB];
    end
  end
endmodule

// File: rtl/alu8_cond.sv
module alu8_cond
  import alu8_pkg::*;
(
  input  flags_t          f,
  input  logic [CC_W-1:0] cc,
  output logic            take
);
  logic sv;
  logic base;

  always_comb begin
    sv = f.s ^ f.v;
    case (cc[CC_W-2:0])
      3'd0: base = 1'b0;
      3'd1: base = sv;
      3'd2: base = f.z | sv;
      3'd3: base = f.c | f.z;
      3'd4: base = f.v;
      3'd5: base = f.s;
      3'd6: base = f.z;
      default: base = f.c;
    endcase
    take = cc[CC_W-1] ? !base : base;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              flag_we,
  input  logic              flag_ld,
  input  logic [FLAG_W-1:0] flag_in,
  input  logic [CC_W-1:0]   cc_sel,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags_out,
  output logic              branch_take
);
  alu_op_e           op;
  flags_t            flags_q, flags_d;
  flags_t            ar_f, lg_f, alu_f;
  logic [DATA_W-1:0] ar_res, lg_res;
  logic              use_arith;

  assign op = alu_op_e'(op_sel);

  alu8_arith u_arith (.op(op), .a(opnd_a), .b(opnd_b), .fin(flags_q),
                      .res(ar_res), .fout(ar_f));
  alu8_logic u_logic (.op(op), .a(opnd_a), .b(opnd_b), .fin(flags_q),
                      .res(lg_res), .fout(lg_f));
  alu8_cond  u_cond  (.f(flags_q), .cc(cc_sel), .take(branch_take));

  always_comb begin
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP,
      OP_INC, OP_DEC, OP_DA: use_arith = 1'b1;
      default:               use_arith = 1'b0;
    endcase
    result = use_arith ? ar_res : lg_res;
    alu_f  = use_arith ? ar_f   : lg_f;
  end

  always_comb begin
    flags_d = flags_q;
    if (flag_ld)      flags_d = flags_t'(flag_in);
    else if (flag_we) flags_d = alu_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else if (flag_ld || flag_we) flags_q <= flags_d;
  end

  assign flags_out = flags_q;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   op_sel,
  input logic [DATA_W-1:0] opnd_a,
  input logic              flag_we,
  input logic              flag_ld,
  input logic [FLAG_W-1:0] flag_in,
  input logic [CC_W-1:0]   cc_sel,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_W-1:0] flags_out,
  input logic              branch_take
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> flags_out == '0);
  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_ld && !flag_we) |=> $stable(flags_out));
  // R2
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ld |=> flags_out == $past(flag_in));
  // R3
  add_dclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_ld && op_sel == OP_ADD) |=> !flags_out[1]);
  // R10
  mask_noresult_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_TM || op_sel == OP_TCM) |-> result == opnd_a);
  // R11
  cc_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_sel == 4'b0000 |-> !branch_take);
  // R11
  cc_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_sel == 4'b1000 |-> branch_take);
endmodule

bind alu8_core alu8_core_chk u_chk (.*);

// File: tb/alu8_core_test.sv
module alu8_core_test;
  import alu8_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op_sel = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic       flag_we = 1'b0, flag_ld = 1'b0;
  logic [5:0] flag_in = '0;
  logic [3:0] cc_sel = '0;
  logic [7:0] result;
  logic [5:0] flags_out;
  logic       branch_take;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  alu8_core uut (.clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .flag_we(flag_we), .flag_ld(flag_ld), .flag_in(flag_in),
    .cc_sel(cc_sel), .result(result), .flags_out(flags_out),
    .branch_take(branch_take));

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic preset(logic [5:0] f);
    @(negedge clk);
    flag_ld = 1'b1; flag_in = f;
    @(negedge clk);
    flag_ld = 1'b0;
  endtask

  // one op, result sampled before the edge, flags after it
  task automatic run_op(string tag, logic [4:0] op, logic [7:0] a, logic [7:0] b,
                        logic [7:0] exp_res, logic [5:0] exp_f);
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; flag_we = 1'b1;
    #1 chk({tag, " result"}, result, exp_res);
    @(negedge clk);
    flag_we = 1'b0;
    chk({tag, " flags"}, {2'b00, flags_out}, {2'b00, exp_f});
  endtask

  function automatic logic cc_ref(logic [3:0] cc, logic [5:0] f);
    logic c, z, s, v;
    {c, z, s, v} = f[5:2];
    case (cc)
      4'b0000: return 1'b0;        4'b1000: return 1'b1;
      4'b0001: return s ^ v;       4'b1001: return !(s ^ v);
      4'b0010: return z | (s ^ v); 4'b1010: return !(z | (s ^ v));
      4'b0011: return c | z;       4'b1011: return !(c | z);
      4'b0100: return v;           4'b1100: return !v;
      4'b0101: return s;           4'b1101: return !s;
      4'b0110: return z;           4'b1110: return !z;
      4'b0111: return c;           default: return !c;
    endcase
  endfunction

  task automatic test_reset();
    chk("R1 flags in reset", {2'b00, flags_out}, 8'h00);
  endtask

  task automatic test_add();
    preset(6'b100000);
    run_op("R3 adc", OP_ADC, 8'h16, 8'h20, 8'h37, 6'b000000);
    preset(6'b000010);
    run_op("R3 add overflow", OP_ADD, 8'h7F, 8'h01, 8'h80, 6'b001101);
    preset(6'b000000);
    run_op("R3 add carry zero", OP_ADD, 8'hFF, 8'h01, 8'h00, 6'b110001);
  endtask

  task automatic test_sub_cmp();
    preset(6'b000000);
    run_op("R4 sub", OP_SUB, 8'h16, 8'h20, 8'hF6, 6'b101010);
    preset(6'b100000);
    run_op("R4 sbc", OP_SBC, 8'h50, 8'h10, 8'h3F, 6'b000011);
    preset(6'b000001);
    run_op("R4 cp", OP_CP, 8'h16, 8'h20, 8'h16, 6'b101001);
  endtask

  task automatic test_logic();
    preset(6'b100111);
    run_op("R5 and", OP_AND, 8'hF0, 8'h0F, 8'h00, 6'b110011);
    preset(6'b000000);
    run_op("R5 xor", OP_XOR, 8'hAA, 8'h55, 8'hFF, 6'b001000);
    run_op("R5 or", OP_OR, 8'h30, 8'h04, 8'h34, 6'b000000);
    run_op("R5 com", OP_COM, 8'h0F, 8'h00, 8'hF0, 6'b001000);
  endtask

  task automatic test_incdec();
    preset(6'b100000);
    run_op("R6 inc", OP_INC, 8'h7F, 8'h00, 8'h80, 6'b101100);
    preset(6'b000000);
    run_op("R6 dec", OP_DEC, 8'h01, 8'h00, 8'h00, 6'b010000);
  endtask

  task automatic test_rotate();
    preset(6'b000000);
    run_op("R7 rl", OP_RL, 8'h81, 8'h00, 8'h03, 6'b100100);
    preset(6'b100000);
    run_op("R7 rlc", OP_RLC, 8'h40, 8'h00, 8'h81, 6'b001100);
    preset(6'b000000);
    run_op("R7 rr", OP_RR, 8'h01, 8'h00, 8'h80, 6'b101100);
    preset(6'b100000);
    run_op("R7 rrc", OP_RRC, 8'h02, 8'h00, 8'h81, 6'b001100);
  endtask

  task automatic test_shift_swap();
    preset(6'b000100);
    run_op("R8 sra", OP_SRA, 8'h81, 8'h00, 8'hC0, 6'b101000);
    preset(6'b100000);
    run_op("R8 swap", OP_SWAP, 8'h3C, 8'h00, 8'hC3, 6'b101000);
  endtask

  task automatic test_decimal();
    preset(6'b000000);
    run_op("R9 add 15+27", OP_ADD, 8'h15, 8'h27, 8'h3C, 6'b000000);
    run_op("R9 da after add", OP_DA, 8'h3C, 8'h00, 8'h42, 6'b000000);
    run_op("R9 sub 25-17", OP_SUB, 8'h25, 8'h17, 8'h0E, 6'b000011);
    run_op("R9 da after sub", OP_DA, 8'h0E, 8'h00, 8'h08, 6'b000011);
    run_op("R9 add 99+01", OP_ADD, 8'h99, 8'h01, 8'h9A, 6'b001000);
    run_op("R9 da carry out", OP_DA, 8'h9A, 8'h00, 8'h00, 6'b110000);
  endtask

  task automatic test_mask();
    preset(6'b100111);
    run_op("R10 tm", OP_TM, 8'h0F, 8'h10, 8'h0F, 6'b110011);
    preset(6'b010000);
    run_op("R10 tcm", OP_TCM, 8'hEF, 8'h10, 8'hEF, 6'b000000);
    preset(6'b101010);
    run_op("R10 unused op", 5'd25, 8'h5A, 8'h11, 8'h5A, 6'b101010);
  endtask

  task automatic test_flag_reg();
    preset(6'b010101);
    chk("R2 load", {2'b00, flags_out}, 8'h15);
    @(negedge clk);
    op_sel = OP_ADD; opnd_a = 8'hFF; opnd_b = 8'h01; flag_we = 1'b0;
    @(negedge clk);
    chk("R2 hold without enable", {2'b00, flags_out}, 8'h15);
    flag_we = 1'b1; flag_ld = 1'b1; flag_in = 6'b001010;
    @(negedge clk);
    flag_we = 1'b0; flag_ld = 1'b0;
    chk("R2 load priority", {2'b00, flags_out}, 8'h0A);
  endtask

  task automatic test_cond();
    for (int f = 0; f < 64; f++) begin
      preset(6'(f));
      for (int cc = 0; cc < 16; cc++) begin
        cc_sel = 4'(cc);
        #0.5;
        chk($sformatf("R11 cc %b flags %b", 4'(cc), 6'(f)),
            {7'd0, branch_take}, {7'd0, cc_ref(4'(cc), 6'(f))});
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_add();
    test_sub_cmp();
    test_logic();
    test_incdec();
    test_rotate();
    test_shift_swap();
    test_decimal();
    test_mask();
    test_flag_reg();
    test_cond();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule